// File: doc/BRIEF.md
# Windowed Interrupt Array Register Bank

This block holds the per-line state for a bank of external interrupt request lines: one enable bit, one force bit and one priority field per line. The number of lines is a parameter, a multiple of 16 and at most 512. Software reaches all of this state through a 32-bit CSR-style port that supports four operations: read, write, bit-set and bit-clear. No access ever moves the whole array. Each access sees a 16-bit slice of the selected array, called a window. The low bits of the same write data pick the window. The upper half of the write data carries the value or mask for that window.

The block also drives a pending vector. Each pending bit is the level-sensitive request input ORed with the line's force bit. The enable vector and the priority fields also leave the block, in flat form, for a downstream next-interrupt selector. That selector can return a clear-force strobe with an interrupt number. When its no-interrupt flag is low, the strobe removes the force bit of the line it names. Priority arbitration itself is done outside this block.

Top module: `irq_array_bank`

## Requirements
- R1: After reset, every enable bit, force bit and priority field is 0. With the request inputs low, every window of every array reads 0.
- R2: `csr_rdata` shows the selected window, as it was before the access, in bits 31:16, and bits 15:0 read 0. Array select `csr_sel` codes are: 0 enable, 1 pending, 2 force, 3 priority. For a write, set or clear, the window index comes from `csr_wdata[4:0]` for the enable, pending and force arrays, and from `csr_wdata[6:0]` for the priority array. Enable, pending and force window w holds lines 16w to 16w+15, with line 16w+b at read bit 16+b.
- R3: Operation `csr_op` codes are: 0 read, 1 write, 2 set, 3 clear. A write replaces the addressed window with `csr_wdata[31:16]`. A set ORs that mask into the window. A clear removes the mask bits from the window. No other window changes.
- R4: `irq_pending` equals `irq_req | force`. The pending array is read-only: write, set and clear operations on it change no state.
- R5: A force bit set by software makes its line pending while the request input is low. Clearing the force bit by software removes that pending state.
- R6: A cycle with `fclr_valid` high, `fclr_noirq` low and `fclr_index` below the line count clears that line's force bit. The clear wins over a software write, set or clear of the same bit in the same cycle. With `fclr_noirq` high, or with an index at or above the line count, the strobe has no effect.
- R7: Priority window p holds lines 4p to 4p+3, with line 4p+k in read bits 16+4k+3 down to 16+4k. `irq_prio` holds line i at bits i*PRIO_BITS+PRIO_BITS-1 down to i*PRIO_BITS.
- R8: With PRIO_BITS below 4, the low 4-PRIO_BITS bits of every priority field read 0 and ignore writes. The field's stored value is its upper PRIO_BITS bits.
- R9: Enable, pending and force windows at or above NUM_IRQ/16, and priority windows at or above NUM_IRQ/4, read 0 and ignore writes.
- R10: A read operation ignores `csr_wdata`, always uses window 0, and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| csr_valid | input | 1 | Access strobe, one access per cycle |
| csr_sel | input | 2 | Array select (0 enable, 1 pending, 2 force, 3 priority) |
| csr_op | input | 2 | Operation (0 read, 1 write, 2 set, 3 clear) |
| csr_wdata | input | 32 | Mask or value in 31:16, window index in the low bits |
| csr_rdata | output | 32 | Selected window before the access, in 31:16 |
| irq_req | input | NUM_IRQ | Level-sensitive request inputs |
| fclr_valid | input | 1 | Clear-force strobe from the next-interrupt selector |
| fclr_noirq | input | 1 | Selector found no interrupt; the strobe is ignored |
| fclr_index | input | 9 | Line number whose force bit is cleared |
| irq_enable | output | NUM_IRQ | Enable bits |
| irq_pending | output | NUM_IRQ | Request ORed with force |
| irq_prio | output | NUM_IRQ*PRIO_BITS | Priority fields, flat |

## Verification
The assertions check on every cycle that the enable and priority outputs change only when that array is written. They also check that writes to out-of-range enable windows leave state alone, that the low half of the read data stays zero, and that a valid clear-force strobe leaves the named line pending only through its request input.

Only the bench scenarios can show the rest. These are the window and bit placement of set, write and clear, the read-before-write return value, the window-0 rule for plain reads, and the precedence of a hardware force clear over a same-cycle software set. They also cover the masking of low priority bits, which the bench compares across a full-width instance and a 3-bit-priority instance driven with the same stimulus.

// File: rtl/irq_array_bank.sv
module irq_array_bank #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          csr_valid,
  input  logic [1:0]                    csr_sel,
  input  logic [1:0]                    csr_op,
  input  logic [31:0]                   csr_wdata,
  output logic [31:0]                   csr_rdata,
  input  logic [NUM_IRQ-1:0]            irq_req,
  input  logic                          fclr_valid,
  input  logic                          fclr_noirq,
  input  logic [8:0]                    fclr_index,
  output logic [NUM_IRQ-1:0]            irq_enable,
  output logic [NUM_IRQ-1:0]            irq_pending,
  output logic [NUM_IRQ*PRIO_BITS-1:0]  irq_prio
);

  localparam int NWIN = NUM_IRQ / 16;
  localparam int NPW  = NUM_IRQ / 4;
  localparam int PSH  = 4 - PRIO_BITS;
  localparam int IW   = $clog2(NUM_IRQ);

  localparam logic [1:0] SEL_EN = 2'd0;
  localparam logic [1:0] SEL_PD = 2'd1;
  localparam logic [1:0] SEL_FR = 2'd2;
  localparam logic [1:0] SEL_PR = 2'd3;
  localparam logic [1:0] OP_RD  = 2'd0;
  localparam logic [1:0] OP_WR  = 2'd1;
  localparam logic [1:0] OP_SET = 2'd2;
  localparam logic [1:0] OP_CLR = 2'd3;

  logic [NUM_IRQ-1:0] en_q, en_d, fr_q, fr_d;
  logic [NUM_IRQ-1:0][PRIO_BITS-1:0] pr_q, pr_d;
  logic        wr;
  logic [4:0]  widx;
  logic [6:0]  pidx;
  logic [15:0] wmask;
  logic [15:0] pr_nv;
  logic [15:0] en_win [32];
  logic [15:0] pd_win [32];
  logic [15:0] fr_win [32];
  logic [15:0] pr_win [128];
  logic        unused_wdata;

  function automatic logic [15:0] apply_op(input logic [1:0] op, input logic [15:0] cur,
                                           input logic [15:0] m);
    case (op)
      OP_WR:   return m;
      OP_SET:  return cur | m;
      OP_CLR:  return cur & ~m;
      default: return cur;
    endcase
  endfunction

  function automatic logic [3:0] widen(input logic [PRIO_BITS-1:0] v);
    return 4'(v) << PSH;
  endfunction

  assign wr           = csr_valid && (csr_op != OP_RD);
  assign widx         = wr ? csr_wdata[4:0] : 5'd0;
  assign pidx         = wr ? csr_wdata[6:0] : 7'd0;
  assign wmask        = csr_wdata[31:16];
  assign unused_wdata = ^csr_wdata[15:7];

  assign irq_enable  = en_q;
  assign irq_pending = irq_req | fr_q;
  assign irq_prio    = pr_q;

  for (genvar w = 0; w < 32; w++) begin : g_win
    if (w < NWIN) begin : g_on
      assign en_win[w] = en_q[w*16 +: 16];
      assign fr_win[w] = fr_q[w*16 +: 16];
      assign pd_win[w] = irq_pending[w*16 +: 16];
    end else begin : g_off
      assign en_win[w] = '0;
      assign fr_win[w] = '0;
      assign pd_win[w] = '0;
    end
  end

  for (genvar p = 0; p < 128; p++) begin : g_pwin
    if (p < NPW) begin : g_on
      assign pr_win[p] = {widen(pr_q[4*p+3]), widen(pr_q[4*p+2]),
                          widen(pr_q[4*p+1]), widen(pr_q[4*p])};
    end else begin : g_off
      assign pr_win[p] = '0;
    end
  end

  assign pr_nv = apply_op(csr_op, pr_win[pidx], wmask);

  always_comb begin
    en_d = en_q;
    fr_d = fr_q;
    pr_d = pr_q;
    for (int w = 0; w < NWIN; w++) begin
      if (wr && csr_sel == SEL_EN && int'(widx) == w)
        en_d[w*16 +: 16] = apply_op(csr_op, en_q[w*16 +: 16], wmask);
      if (wr && csr_sel == SEL_FR && int'(widx) == w)
        fr_d[w*16 +: 16] = apply_op(csr_op, fr_q[w*16 +: 16], wmask);
    end
    for (int p = 0; p < NPW; p++) begin
      if (wr && csr_sel == SEL_PR && int'(pidx) == p)
        for (int k = 0; k < 4; k++)
          pr_d[4*p+k] = pr_nv[4*k+PSH +: PRIO_BITS];
    end
    if (fclr_valid && !fclr_noirq && int'(fclr_index) < NUM_IRQ)
      fr_d[fclr_index[IW-1:0]] = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      fr_q <= '0;
      pr_q <= '0;
    end else begin
      en_q <= en_d;
      fr_q <= fr_d;
      pr_q <= pr_d;
    end
  end

  always_comb begin
    case (csr_sel)
      SEL_EN:  csr_rdata = {en_win[widx], 16'h0};
      SEL_PD:  csr_rdata = {pd_win[widx], 16'h0};
      SEL_FR:  csr_rdata = {fr_win[widx], 16'h0};
      default: csr_rdata = {pr_win[pidx], 16'h0};
    endcase
  end

endmodule

module irq_array_bank_chk #(
  parameter int NUM_IRQ   = 64,
  parameter int PRIO_BITS = 4
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         csr_valid,
  input logic [1:0]                   csr_sel,
  input logic [1:0]                   csr_op,
  input logic [31:0]                  csr_wdata,
  input logic [31:0]                  csr_rdata,
  input logic [NUM_IRQ-1:0]           irq_req,
  input logic                         fclr_valid,
  input logic                         fclr_noirq,
  input logic [8:0]                   fclr_index,
  input logic [NUM_IRQ-1:0]           irq_enable,
  input logic [NUM_IRQ-1:0]           irq_pending,
  input logic [NUM_IRQ*PRIO_BITS-1:0] irq_prio
);
  localparam int IW   = $clog2(NUM_IRQ);
  localparam int NWIN = NUM_IRQ / 16;

  a_r3_enable_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_valid && csr_sel == 2'd0 && csr_op != 2'd0) |=> $stable(irq_enable));

  a_r7_prio_only_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    !(csr_valid && csr_sel == 2'd3 && csr_op != 2'd0) |=> $stable(irq_prio));

  a_r9_enable_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_valid && csr_sel == 2'd0 && csr_op != 2'd0 && int'(csr_wdata[4:0]) >= NWIN)
    |=> $stable(irq_enable));

  a_r6_hw_force_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (fclr_valid && !fclr_noirq && int'(fclr_index) < NUM_IRQ)
    |=> irq_pending[$past(fclr_index[IW-1:0])] == irq_req[$past(fclr_index[IW-1:0])]);

  a_r2_low_half_zero: assert property (@(posedge clk) disable iff (!rst_n)
    csr_valid |-> csr_rdata[15:0] == 16'h0);
endmodule

bind irq_array_bank irq_array_bank_chk #(.NUM_IRQ(NUM_IRQ), .PRIO_BITS(PRIO_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_sel(csr_sel), .csr_op(csr_op),
  .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .irq_req(irq_req), .fclr_valid(fclr_valid),
  .fclr_noirq(fclr_noirq), .fclr_index(fclr_index), .irq_enable(irq_enable),
  .irq_pending(irq_pending), .irq_prio(irq_prio));

// File: tb/test_irq_array_bank.sv
module test_irq_array_bank;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic csr_valid = 1'b0;
  logic [1:0] csr_sel = 2'd0;
  logic [1:0] csr_op = 2'd0;
  logic [31:0] csr_wdata = 32'h0;
  logic [63:0] irq_req = 64'h0;
  logic fclr_valid = 1'b0;
  logic fclr_noirq = 1'b0;
  logic [8:0] fclr_index = 9'd0;
  logic [31:0] rd4, rd3;
  logic [63:0] en4, pd4, en3, pd3;
  logic [255:0] pr4;
  logic [191:0] pr3;

  int n_tests = 0;
  int n_fail = 0;

  logic [63:0] m_en = 64'h0;
  logic [63:0] m_fr = 64'h0;
  logic [3:0]  m_pr [64];

  always #5 clk = ~clk;

  irq_array_bank #(.NUM_IRQ(64), .PRIO_BITS(4)) i_irq_array_bank (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_sel(csr_sel), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_rdata(rd4), .irq_req(irq_req), .fclr_valid(fclr_valid),
    .fclr_noirq(fclr_noirq), .fclr_index(fclr_index), .irq_enable(en4),
    .irq_pending(pd4), .irq_prio(pr4));

  irq_array_bank #(.NUM_IRQ(64), .PRIO_BITS(3)) i_irq_array_bank_p3 (
    .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid), .csr_sel(csr_sel), .csr_op(csr_op),
    .csr_wdata(csr_wdata), .csr_rdata(rd3), .irq_req(irq_req), .fclr_valid(fclr_valid),
    .fclr_noirq(fclr_noirq), .fclr_index(fclr_index), .irq_enable(en3),
    .irq_pending(pd3), .irq_prio(pr3));

  task automatic chk(input string tag, input logic [255:0] got, input logic [255:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=%h exp=%h", tag, got, exp);
    end
  endtask

  function automatic logic [15:0] mupd(input logic [1:0] op, input logic [15:0] c,
                                       input logic [15:0] m);
    if (op == 2'd1) return m;
    if (op == 2'd2) return c | m;
    if (op == 2'd3) return c & ~m;
    return c;
  endfunction

  function automatic logic [15:0] pwin(input int p, input bit low_masked);
    logic [15:0] v = '0;
    if (p < 16)
      for (int k = 0; k < 4; k++)
        v[4*k +: 4] = low_masked ? (m_pr[4*p+k] & 4'hE) : m_pr[4*p+k];
    return v;
  endfunction

  function automatic logic [15:0] ewin(input logic [1:0] sel, input int idx, input bit lm);
    logic [63:0] pend = irq_req | m_fr;
    if (sel == 2'd3) return pwin(idx, lm);
    if (idx >= 4) return 16'h0;
    if (sel == 2'd0) return m_en[idx*16 +: 16];
    if (sel == 2'd1) return pend[idx*16 +: 16];
    return m_fr[idx*16 +: 16];
  endfunction

  task automatic chk_outs(input string tag);
    logic [255:0] f4 = '0;
    logic [191:0] f3 = '0;
    for (int i = 0; i < 64; i++) begin
      f4[i*4 +: 4] = m_pr[i];
      f3[i*3 +: 3] = m_pr[i][3:1];
    end
    chk({tag, " enable"}, {192'h0, en4}, {192'h0, m_en});
    chk({tag, " pending"}, {192'h0, pd4}, {192'h0, irq_req | m_fr});
    chk({tag, " prio"}, pr4, f4);
    chk({tag, " enable p3"}, {192'h0, en3}, {192'h0, m_en});
    chk({tag, " pending p3"}, {192'h0, pd3}, {192'h0, irq_req | m_fr});
    chk({tag, " prio p3"}, {64'h0, pr3}, {64'h0, f3});
  endtask

  task automatic access(input logic [1:0] sel, input logic [1:0] op, input logic [31:0] wd,
                        input string tag);
    int idx;
    logic [15:0] nv;
    @(negedge clk);
    csr_valid = 1'b1;
    csr_sel = sel;
    csr_op = op;
    csr_wdata = wd;
    idx = (op == 2'd0) ? 0 : ((sel == 2'd3) ? int'(wd[6:0]) : int'(wd[4:0]));
    #1;
    chk({tag, " rdata"}, {224'h0, rd4}, {224'h0, ewin(sel, idx, 1'b0), 16'h0});
    chk({tag, " rdata p3"}, {224'h0, rd3}, {224'h0, ewin(sel, idx, 1'b1), 16'h0});
    if (op != 2'd0) begin
      if (sel == 2'd0 && idx < 4) m_en[idx*16 +: 16] = mupd(op, m_en[idx*16 +: 16], wd[31:16]);
      if (sel == 2'd2 && idx < 4) m_fr[idx*16 +: 16] = mupd(op, m_fr[idx*16 +: 16], wd[31:16]);
      if (sel == 2'd3 && idx < 16) begin
        nv = mupd(op, pwin(idx, 1'b0), wd[31:16]);
        for (int k = 0; k < 4; k++) m_pr[4*idx+k] = nv[4*k +: 4];
      end
    end
    if (fclr_valid && !fclr_noirq && fclr_index < 9'd64) m_fr[fclr_index[5:0]] = 1'b0;
    @(posedge clk);
    #1;
    csr_valid = 1'b0;
    fclr_valid = 1'b0;
  endtask

  initial begin
    #500us;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) m_pr[i] = 4'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk_outs("R1");
    for (int s = 0; s < 4; s++)
      for (int w = 0; w < 32; w++)
        access(2'(s), 2'd2, {16'h0, 16'(w)}, "R1");

    for (int i = 0; i < 64; i++)
      access(2'd0, 2'd2, {16'(1 << (i % 16)), 16'(i / 16)}, "R3 set");
    chk_outs("R3 set");
    for (int i = 0; i < 64; i += 3)
      access(2'd0, 2'd3, {16'(1 << (i % 16)), 16'(i / 16)}, "R3 clear");
    chk_outs("R3 clear");
    for (int w = 0; w < 4; w++)
      access(2'd0, 2'd1, {16'(w * 16'h3C5A) ^ 16'hA5F0, 16'(w)}, "R3 write");
    chk_outs("R3 write");
    for (int w = 0; w < 4; w++) access(2'd0, 2'd2, {16'h0, 16'(w)}, "R2 readback");

    access(2'd0, 2'd0, {16'hFFFF, 16'h0002}, "R10 read");
    access(2'd3, 2'd0, {16'hFFFF, 16'h0005}, "R10 read prio");
    chk_outs("R10");

    irq_req = 64'h0123_4567_89AB_CDEF;
    for (int w = 0; w < 4; w++) access(2'd1, 2'd2, {16'h0, 16'(w)}, "R4 pend read");
    access(2'd1, 2'd1, {16'hFFFF, 16'h0000}, "R4 pend write");
    access(2'd1, 2'd3, {16'hFFFF, 16'h0001}, "R4 pend clear");
    chk_outs("R4");
    irq_req = 64'hF0F0_0000_FFFF_0001;
    #1;
    chk_outs("R4 level");

    irq_req = 64'h0;
    access(2'd2, 2'd1, {16'h8421, 16'h0000}, "R5 force");
    access(2'd2, 2'd2, {16'h00F0, 16'h0003}, "R5 force");
    chk_outs("R5 force");
    for (int w = 0; w < 4; w++) access(2'd1, 2'd2, {16'h0, 16'(w)}, "R5 pend read");
    access(2'd2, 2'd3, {16'h0400, 16'h0000}, "R5 unforce");
    chk_outs("R5 unforce");

    access(2'd2, 2'd1, {16'hFFFF, 16'h0002}, "R6 prep");
    fclr_valid = 1'b1; fclr_noirq = 1'b1; fclr_index = 9'd37;
    access(2'd0, 2'd0, 32'h0, "R6 noirq");
    chk_outs("R6 noirq");
    fclr_valid = 1'b1; fclr_noirq = 1'b0; fclr_index = 9'd37;
    access(2'd0, 2'd0, 32'h0, "R6 clear");
    chk_outs("R6 clear");
    fclr_valid = 1'b1; fclr_noirq = 1'b0; fclr_index = 9'd300;
    access(2'd0, 2'd0, 32'h0, "R6 range");
    chk_outs("R6 range");
    fclr_valid = 1'b1; fclr_noirq = 1'b0; fclr_index = 9'd40;
    access(2'd2, 2'd2, {16'hFFFF, 16'h0002}, "R6 precedence");
    chk_outs("R6 precedence");

    for (int p = 0; p < 16; p++)
      access(2'd3, 2'd1, {16'(p * 16'h1111) ^ 16'h5A3C, 16'(p)}, "R7 write");
    chk_outs("R7 write");
    access(2'd3, 2'd2, {16'h8001, 16'h0004}, "R8 set");
    access(2'd3, 2'd3, {16'hF0F1, 16'h000B}, "R8 clear");
    chk_outs("R8");
    for (int p = 0; p < 16; p++) access(2'd3, 2'd2, {16'h0, 16'(p)}, "R7 readback");

    for (int w = 4; w < 32; w++) begin
      access(2'd0, 2'd1, {16'hFFFF, 16'(w)}, "R9 enable");
      access(2'd2, 2'd2, {16'hFFFF, 16'(w)}, "R9 force");
    end
    for (int p = 16; p < 128; p++) access(2'd3, 2'd1, {16'hFFFF, 16'(p)}, "R9 prio");
    chk_outs("R9");

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule